// File: doc/BRIEF.md
# SMBus Block-Transfer Configuration Register Slave

This block is a serial management bus slave that holds a small bank of 8-bit configuration registers and presents their values to the rest of the chip. A host reaches the bank with block transfers. Every transaction first sets a starting register index. A write then gives a byte count and that many data bytes. A read opens with a repeated start and gets back the programmable byte count, followed by register contents. The index pointer steps forward after every data byte.

The clock and data lines are open-drain. Both are sampled by the fast system clock through a synchronizer, and the block pulls the data line low only through `sdaOe`. A set of strap inputs is captured while reset is held. These values go into the control register and into a read-only copy register. While an override bit in the control register is clear, the captured strap bits in the control register are protected from writes.

Top module: `smbus_cfg_slave`

## Requirements
- R1: An address byte of 0xDC (write) or 0xDD (read) is acknowledged. Any other address byte is not acknowledged, and the block then ignores all bytes and changes no register until the next start.
- R2: In a block write, the block takes the index byte N, then the count byte X, then data bytes that go to registers N, N+1, … in turn. The index advances by one after each stored byte.
- R3: Data bytes beyond the count X of a block write are acknowledged but change no register. A count of 0 stores nothing.
- R4: In a block read after 0xDD, the block first sends the content of register 6 (the count), then the registers from the current index upward, one per host acknowledge. A host NACK ends the transmission.
- R5: After reset, register 1 (output enables, `cfgOutEn`) is 0xFF, register 2 (stop flags, `cfgStop`) is 0x80 and register 6 (count, `cfgCount`) is 0x07. Register 4 reads 0x01 and register 5 reads 0x07 at all times.
- R6: At reset, `strapIn[5:1]` load register 0 bits 7..3 and `strapIn[0]` loads register 0 bit 0. Register 0 bits 2 and 1 reset to 0. Register 3 holds the same captured bits in the same positions, with bits 2 and 1 reading 0.
- R7: A write to register 0 changes bits 7..3 and 0 only if register 0 bit 2 was already 1 before that write. Bits 2 and 1 are always written.
- R8: Writes to registers 3, 4 and 5, and to indices 7 and above, are acknowledged and discarded. Reads of indices 7 and above return 0x00.
- R9: A start or repeated start is a fall of the data line while the clock line is high. A stop is a rise of the data line while the clock line is high. A stop abandons a partial byte, and the block then responds normally to the next start. The block changes `sdaOe` only while the synchronized clock line is low.
- R10: The block acknowledges by asserting `sdaOe` (pulling the data line low) for the ninth clock of every byte it accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset; straps are captured while it is low |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| strapIn | input | 6 | Strap pin levels to capture at reset |
| sdaOe | output | 1 | 1 pulls the data line low |
| cfgCtrl | output | 8 | Register 0, control and captured straps |
| cfgOutEn | output | 8 | Register 1, output enables |
| cfgStop | output | 8 | Register 2, stop-mode flags |
| cfgCount | output | 8 | Register 6, read byte count |

## Verification
Reset is swept across eight strap patterns, and each is followed by a full read from index 0 through index 7. This separates a wrong strap bit placement from wrong constants, from an out-of-range read, and from a missing count byte. Sixteen block writes with distinct data check placement and auto-increment. Further cases write beyond the count, with a zero count, to read-only and out-of-range indices, and to the control register with the override bit clear and then set, which separates the two write paths. Four non-matching address bytes and an aborted byte ended by a stop check that the slave stays silent and that it recovers.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  typedef struct packed {
    logic loadIndex;
    logic loadCount;
    logic writeByte;
    logic advance;
  } regStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } ctlState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } byteKind_t;

  localparam logic [7:0] REG_CTRL   = 8'd0;
  localparam logic [7:0] REG_OUTEN  = 8'd1;
  localparam logic [7:0] REG_STOP   = 8'd2;
  localparam logic [7:0] REG_STRAPS = 8'd3;
  localparam logic [7:0] REG_VENDOR = 8'd4;
  localparam logic [7:0] REG_DEVID  = 8'd5;
  localparam logic [7:0] REG_COUNT  = 8'd6;

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/smbus_ctrl.sv
module smbus_ctrl
  import smbus_cfg_pkg::*;
#(
  parameter logic [7:0] ADDR_WR = 8'hDC
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rdByte,
  input  logic [7:0] countByte,
  output regStrobe_t strb,
  output logic [7:0] rxByte,
  output logic       sdaOe
);

  localparam logic [7:0] ADDR_RD = ADDR_WR | 8'h01;
  localparam logic [3:0] BYTE_BITS = 4'd8;

  ctlState_t state;
  byteKind_t kind;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic [7:0] txShift;
  logic       readMode;
  logic       hostAck;
  logic       addrHit;

  assign addrHit = (shReg == ADDR_WR) || (shReg == ADDR_RD);
  assign rxByte  = shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      bitCnt   <= '0;
      shReg    <= '0;
      txShift  <= '0;
      readMode <= 1'b0;
      hostAck  <= 1'b0;
      sdaOe    <= 1'b0;
      strb     <= '0;
    end else begin
      strb <= '0;
      if (startDet) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise && bitCnt != BYTE_BITS) begin
              shReg  <= {shReg[6:0], sdaLvl};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == BYTE_BITS) begin
              case (kind)
                K_ADDR: begin
                  if (addrHit) begin
                    readMode <= shReg[0];
                    sdaOe    <= 1'b1;
                    state    <= S_RX_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                K_INDEX: begin
                  strb.loadIndex <= 1'b1;
                  sdaOe <= 1'b1;
                  state <= S_RX_ACK;
                end
                K_COUNT: begin
                  strb.loadCount <= 1'b1;
                  sdaOe <= 1'b1;
                  state <= S_RX_ACK;
                end
                default: begin
                  strb.writeByte <= 1'b1;
                  sdaOe <= 1'b1;
                  state <= S_RX_ACK;
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (kind == K_ADDR && readMode) begin
                txShift <= countByte;
                sdaOe   <= ~countByte[7];
                state   <= S_TX;
              end else begin
                sdaOe <= 1'b0;
                state <= S_RX;
                case (kind)
                  K_ADDR:  kind <= K_INDEX;
                  K_INDEX: kind <= K_COUNT;
                  default: kind <= K_DATA;
                endcase
              end
            end
          end
          S_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == BYTE_BITS) begin
                sdaOe <= 1'b0;
                state <= S_TX_ACK;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaOe   <= ~txShift[6];
              end
            end
          end
          S_TX_ACK: begin
            if (sclRise) begin
              hostAck <= ~sdaLvl;
            end else if (sclFall) begin
              bitCnt <= '0;
              if (hostAck) begin
                txShift      <= rdByte;
                sdaOe        <= ~rdByte[7];
                strb.advance <= 1'b1;
                state        <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/smbus_regs.sv
module smbus_regs
  import smbus_cfg_pkg::*;
#(
  parameter int         STRAP_W     = 6,
  parameter int         REG_NUM     = 7,
  parameter logic [7:0] DEVICE_ID   = 8'h07,
  parameter logic [7:0] VENDOR_REV  = 8'h01,
  parameter logic [7:0] COUNT_RESET = 8'h07,
  parameter logic [7:0] OUTEN_RESET = 8'hFF,
  parameter logic [7:0] STOP_RESET  = 8'h80,
  parameter int         OVR_BIT     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [7:0]         rdByte,
  output logic [7:0]         cfgCtrl,
  output logic [7:0]         cfgOutEn,
  output logic [7:0]         cfgStop,
  output logic [7:0]         cfgCount
);

  localparam logic [7:0] STRAP_MASK = 8'hF9;
  localparam logic [7:0] LAST_IDX   = 8'(REG_NUM - 1);

  logic [7:0] ctrlReg, outEnReg, stopReg, countReg, strapCopy;
  logic [7:0] idx;
  logic [7:0] remain;
  logic [7:0] strapBits;
  logic [7:0] ctrlNext;

  assign strapBits = {strapIn[STRAP_W-1:1], 2'b00, strapIn[0]};
  assign ctrlNext  = ctrlReg[OVR_BIT] ? rxByte
                   : ((ctrlReg & STRAP_MASK) | (rxByte & ~STRAP_MASK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= strapBits;
      strapCopy <= strapBits;
      outEnReg  <= OUTEN_RESET;
      stopReg   <= STOP_RESET;
      countReg  <= COUNT_RESET;
      idx       <= '0;
      remain    <= '0;
    end else begin
      if (strb.loadIndex) idx <= rxByte;
      if (strb.loadCount) remain <= rxByte;
      if (strb.advance) idx <= idx + 8'd1;
      if (strb.writeByte && remain != 8'd0) begin
        remain <= remain - 8'd1;
        idx    <= idx + 8'd1;
        case (idx)
          REG_CTRL:  ctrlReg  <= ctrlNext;
          REG_OUTEN: outEnReg <= rxByte;
          REG_STOP:  stopReg  <= rxByte;
          REG_COUNT: countReg <= rxByte;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (idx <= LAST_IDX) begin
      case (idx)
        REG_CTRL:   rdByte = ctrlReg;
        REG_OUTEN:  rdByte = outEnReg;
        REG_STOP:   rdByte = stopReg;
        REG_STRAPS: rdByte = strapCopy;
        REG_VENDOR: rdByte = VENDOR_REV;
        REG_DEVID:  rdByte = DEVICE_ID;
        REG_COUNT:  rdByte = countReg;
        default:    rdByte = 8'h00;
      endcase
    end
  end

  assign cfgCtrl  = ctrlReg;
  assign cfgOutEn = outEnReg;
  assign cfgStop  = stopReg;
  assign cfgCount = countReg;

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         STRAP_W     = 6,
  parameter logic [7:0] ADDR_WR     = 8'hDC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  output logic               sdaOe,
  output logic [7:0]         cfgCtrl,
  output logic [7:0]         cfgOutEn,
  output logic [7:0]         cfgStop,
  output logic [7:0]         cfgCount
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  regStrobe_t ctlStrb;
  logic [7:0] rxByte, rdByte;

  smbus_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  smbus_ctrl #(.ADDR_WR(ADDR_WR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLvl(sdaLvl), .startDet(startDet), .stopDet(stopDet),
    .rdByte(rdByte), .countByte(cfgCount), .strb(ctlStrb),
    .rxByte(rxByte), .sdaOe(sdaOe)
  );

  smbus_regs #(.STRAP_W(STRAP_W)) i_regs (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .rxByte(rxByte),
    .strapIn(strapIn), .rdByte(rdByte), .cfgCtrl(cfgCtrl),
    .cfgOutEn(cfgOutEn), .cfgStop(cfgStop), .cfgCount(cfgCount)
  );

endmodule

// File: rtl/smbus_cfg_checker.sv
module smbus_cfg_checker
  import smbus_cfg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclLvl,
  input logic       startDet,
  input logic       stopDet,
  input logic       sdaOe,
  input regStrobe_t strb,
  input logic [7:0] cfgCtrl,
  input logic [7:0] cfgOutEn
);

  // R9: the slave moves the data line only while the clock line is low
  p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R9: a start leaves the data line released
  p_start_releases_r9: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  // R1: a stop returns the slave to a released, idle line
  p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R2: at most one register strobe per cycle
  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R2: output enables change only after a data-byte strobe
  p_outen_needs_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.writeByte |=> $stable(cfgOutEn));

  // R7: strap bits of the control register are frozen while override is clear
  p_strap_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgCtrl[2] |=> ((cfgCtrl & 8'hF9) == $past(cfgCtrl & 8'hF9)));

endmodule

bind smbus_cfg_slave smbus_cfg_checker i_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .strb(ctlStrb),
  .cfgCtrl(cfgCtrl), .cfgOutEn(cfgOutEn)
);

// File: tb/test_smbus_cfg_slave.sv
module test_smbus_cfg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic [5:0] strapIn = '0;
  logic sdaOe;
  logic [7:0] cfgCtrl, cfgOutEn, cfgStop, cfgCount;
  wire sdaWire = sdaHost & ~sdaOe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] rbuf [0:15];
  logic [7:0] wbuf [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_slave i_smbus_cfg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaWire),
    .strapIn(strapIn), .sdaOe(sdaOe), .cfgCtrl(cfgCtrl),
    .cfgOutEn(cfgOutEn), .cfgStop(cfgStop), .cfgCount(cfgCount)
  );

  function automatic logic [7:0] expand(input logic [5:0] s);
    return {s[5:1], 2'b00, s[0]};
  endfunction

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic applyReset(input logic [5:0] s);
    @(negedge clk);
    rstN = 1'b0; strapIn = s; sclHost = 1'b1; sdaHost = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    sdaHost = 1'b1; waitQ(1);
    sclHost = 1'b1; waitQ(1);
    sdaHost = 1'b0; waitQ(1);
    sclHost = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaHost = 1'b0; waitQ(1);
    sclHost = 1'b1; waitQ(1);
    sdaHost = 1'b1; waitQ(1);
  endtask

  task automatic sendBit(input logic b);
    sdaHost = b; waitQ(1);
    sclHost = 1'b1; waitQ(2);
    sclHost = 1'b0; waitQ(1);
  endtask

  task automatic recvBit(output logic b);
    sdaHost = 1'b1; waitQ(1);
    sclHost = 1'b1; waitQ(1);
    b = sdaWire; waitQ(1);
    sclHost = 1'b0; waitQ(1);
  endtask

  task automatic putByte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    acked = ~b;
  endtask

  task automatic getByte(output logic [7:0] d, input logic ackIt);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(~ackIt);
  endtask

  task automatic blockWrite(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    logic a;
    busStart();
    putByte(8'hDC, a); checkVal("R1 write address ack", {7'b0, a}, 8'h01);
    putByte(idx, a);   checkVal("R10 index ack", {7'b0, a}, 8'h01);
    putByte(cnt, a);   checkVal("R10 count ack", {7'b0, a}, 8'h01);
    for (int i = 0; i < n; i++) begin
      putByte(wbuf[i], a);
      checkVal("R10 data ack", {7'b0, a}, 8'h01);
    end
    busStop();
    waitQ(1);
  endtask

  task automatic blockRead(input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] d;
    busStart();
    putByte(8'hDC, a); checkVal("R1 write address ack", {7'b0, a}, 8'h01);
    putByte(idx, a);   checkVal("R10 index ack", {7'b0, a}, 8'h01);
    busStart();
    putByte(8'hDD, a); checkVal("R1 read address ack", {7'b0, a}, 8'h01);
    getByte(d, 1'b1);
    rbuf[0] = d;
    for (int i = 0; i < n; i++) begin
      getByte(d, i != n - 1);
      rbuf[i + 1] = d;
    end
    busStop();
    waitQ(1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] v, expStop, addr;
    logic [5:0] s;

    // Strap sweep: reset state and full readback (R4 R5 R6 R8)
    for (int ps = 0; ps < 8; ps++) begin
      s = 6'(ps * 9);
      applyReset(s);
      checkVal("R6 ctrl strap capture", cfgCtrl, expand(s));
      checkVal("R5 outEn reset", cfgOutEn, 8'hFF);
      checkVal("R5 stop reset", cfgStop, 8'h80);
      checkVal("R5 count reset", cfgCount, 8'h07);
      checkVal("R10 released at reset", {7'b0, sdaOe}, 8'h00);
      blockRead(8'd0, 8);
      checkVal("R4 count byte first", rbuf[0], 8'h07);
      checkVal("R6 reg0 readback", rbuf[1], expand(s));
      checkVal("R5 reg1 readback", rbuf[2], 8'hFF);
      checkVal("R5 reg2 readback", rbuf[3], 8'h80);
      checkVal("R6 reg3 strap copy", rbuf[4], expand(s));
      checkVal("R5 reg4 vendor", rbuf[5], 8'h01);
      checkVal("R5 reg5 device", rbuf[6], 8'h07);
      checkVal("R4 reg6 count", rbuf[7], 8'h07);
      checkVal("R8 index7 reads zero", rbuf[8], 8'h00);
    end

    applyReset(6'h2A);

    // Non-matching addresses (R1)
    for (int k = 0; k < 4; k++) begin
      addr = (k == 0) ? 8'hA0 : (k == 1) ? 8'hDE : (k == 2) ? 8'h5C : 8'h5D;
      busStart();
      putByte(addr, a);  checkVal("R1 foreign address nack", {7'b0, a}, 8'h00);
      putByte(8'h01, a); checkVal("R1 idle after nack", {7'b0, a}, 8'h00);
      putByte(8'h01, a); checkVal("R1 idle after nack", {7'b0, a}, 8'h00);
      putByte(8'h00, a); checkVal("R1 idle after nack", {7'b0, a}, 8'h00);
      busStop();
      checkVal("R1 no register change", cfgOutEn, 8'hFF);
      checkVal("R1 no register change", cfgStop, 8'h80);
    end

    // Write sweep with auto-increment (R2)
    expStop = 8'h80;
    for (int k = 0; k < 16; k++) begin
      v = 8'(k);
      wbuf[0] = (v * 8'h11) ^ 8'h3C;
      wbuf[1] = ~(v * 8'h0F);
      blockWrite(8'd1, 8'd2, 2);
      checkVal("R2 first byte to index N", cfgOutEn, (v * 8'h11) ^ 8'h3C);
      checkVal("R2 second byte to N+1", cfgStop, ~(v * 8'h0F));
      expStop = ~(v * 8'h0F);
    end

    // Bytes beyond the count (R3)
    wbuf[0] = 8'h12; wbuf[1] = 8'h34;
    blockWrite(8'd1, 8'd1, 2);
    checkVal("R3 counted byte stored", cfgOutEn, 8'h12);
    checkVal("R3 extra byte discarded", cfgStop, expStop);
    wbuf[0] = 8'h99;
    blockWrite(8'd2, 8'd0, 1);
    checkVal("R3 zero count stores nothing", cfgStop, expStop);

    // Strap override (R7)
    wbuf[0] = 8'hFF;
    blockWrite(8'd0, 8'd1, 1);
    checkVal("R7 locked strap bits", cfgCtrl, expand(6'h2A) | 8'h06);
    wbuf[0] = 8'h00;
    blockWrite(8'd0, 8'd1, 1);
    checkVal("R7 override allows write", cfgCtrl, 8'h00);
    wbuf[0] = 8'hFF;
    blockWrite(8'd0, 8'd1, 1);
    checkVal("R7 relocked after clear", cfgCtrl, 8'h06);

    // Read-only and out-of-range writes (R8)
    wbuf[0] = 8'h00; wbuf[1] = 8'hFF; wbuf[2] = 8'h00; wbuf[3] = 8'h05;
    blockWrite(8'd3, 8'd4, 4);
    checkVal("R8 count reg writable", cfgCount, 8'h05);
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    blockWrite(8'd7, 8'd2, 2);
    blockRead(8'd3, 6);
    checkVal("R4 count byte reflects write", rbuf[0], 8'h05);
    checkVal("R8 reg3 ignores write", rbuf[1], expand(6'h2A));
    checkVal("R8 reg4 ignores write", rbuf[2], 8'h01);
    checkVal("R8 reg5 ignores write", rbuf[3], 8'h07);
    checkVal("R8 reg6 readback", rbuf[4], 8'h05);
    checkVal("R8 index7 zero", rbuf[5], 8'h00);
    checkVal("R8 index8 zero", rbuf[6], 8'h00);

    // Aborted byte then recovery (R9)
    busStart();
    putByte(8'hDC, a);
    putByte(8'h01, a);
    putByte(8'h01, a);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    waitQ(1);
    checkVal("R9 partial byte discarded", cfgOutEn, 8'h12);
    checkVal("R9 released after stop", {7'b0, sdaOe}, 8'h00);
    wbuf[0] = 8'h77;
    blockWrite(8'd1, 8'd1, 1);
    checkVal("R9 recovers after stop", cfgOutEn, 8'h77);

    // Short reads ended by NACK (R4)
    blockRead(8'd1, 1);
    checkVal("R4 short read count", rbuf[0], 8'h05);
    checkVal("R4 short read data", rbuf[1], 8'h77);
    blockRead(8'd2, 2);
    checkVal("R4 second read count", rbuf[0], 8'h05);
    checkVal("R4 second read reg2", rbuf[1], expStop);
    checkVal("R4 second read reg3", rbuf[2], expand(6'h2A));
    checkVal("R10 released when idle", {7'b0, sdaOe}, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule